// File: doc/BRIEF.md
# Ethernet Receive Frame Status Classifier

This block watches one received Ethernet frame at a time as it passes on a byte stream. It counts the bytes, records the error events seen along the way, and when the frame ends it reports a 16-bit bit-mapped receive status word, the frame length and an interrupt request. CRC computation, address filtering and the DMA that stores the frame are outside it. The CRC result comes in as a single flag that is valid with the last byte.

A frame opens on a cycle with both `rx_sof` and `rx_valid` high. It closes on the cycle whose valid byte carries `rx_eof`, or early if reception is stopped. One cycle after the closing cycle, `stat_done` pulses for a single cycle. `stat_word` and `frame_len` change on that same cycle and then hold their values until the next frame closes. The receive DMA or the status writer consumes the pulse and writes the word into the frame descriptor.

Top module: `rx_stat_classifier`

## Requirements
- R1: One cycle after the cycle carrying the `rx_eof` byte, `stat_done` is high for exactly one cycle, and `frame_len` equals the number of valid bytes accepted in the frame, counting both the first and the last byte.
- R2: Status bit 3 (over-maximum) is set when the frame length exceeds 1520 bytes.
- R3: Status bit 11 (long) is set when the frame length exceeds 1518 bytes and `long_en` is low at the end of the frame. When `long_en` is high, bit 11 is never set.
- R4: Status bit 8 (alignment) is set when `rx_resid` is nonzero at the last byte and `rx_crc_ok` is low. A nonzero residue with a good CRC does not set it.
- R5: Status bit 9 (CRC) is set when `rx_crc_ok` is low at the last byte, or when `rx_phy_err` was high on any cycle of the frame.
- R6: Status bit 10 (overflow) is set when any accepted byte arrived while `rx_fifo_full` was high.
- R7: Status bit 5 (control frame) is set when byte 12 is 0x88 and byte 13 is 0x08, with the first byte numbered 0. A frame that ends before byte 13 never sets it.
- R8: Status bit 7 copies `path_10m` as sampled at the end of the frame.
- R9: Status bit 14 (good) is set exactly when none of bits 3, 8, 9, 10, 11 and 15 is set.
- R10: If `rx_enable` goes low or `halt_now` goes high during a frame, the frame ends on that cycle. The byte on that cycle is not counted. The done pulse follows one cycle later with bit 15 (halted) set. CRC and alignment are not judged from `rx_crc_ok`, but events already recorded (PHY error, overflow) still report.
- R11: Status bit 6 and the `irq` pulse (given alongside `stat_done`) are set when any error bit (3, 8, 9, 10, 11, 15) is set, or when the frame is good and `good_int_en` is high.
- R12: A start of frame is ignored while `rx_enable` is low or `halt_now` is high. Such a frame produces no done pulse.
- R13: After reset, `stat_done` and `irq` are low, and `stat_word` and `frame_len` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sof | input | 1 | First byte of a frame (qualified by `rx_valid`) |
| rx_valid | input | 1 | Byte valid |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | Last byte of the frame (qualified by `rx_valid`) |
| rx_resid | input | 3 | Bits beyond the last whole byte, valid with `rx_eof` |
| rx_phy_err | input | 1 | PHY receive error |
| rx_fifo_full | input | 1 | Receive FIFO full |
| rx_crc_ok | input | 1 | External CRC check passed, valid with `rx_eof` |
| rx_enable | input | 1 | Reception enabled |
| halt_now | input | 1 | Immediate halt request |
| long_en | input | 1 | Accept frames over 1518 bytes without flagging them long |
| good_int_en | input | 1 | Interrupt on good frames too |
| path_10m | input | 1 | Frame arrives over the 10 Mb/s serial path, not MII |
| stat_word | output | 16 | Receive status word |
| frame_len | output | 16 | Received length in bytes |
| stat_done | output | 1 | One-cycle status-valid strobe |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench probes each side of the size limits: 1518 and 1519 bytes with long frames disallowed, 1519 to 1521 bytes with them allowed, and 1521 bytes with them disallowed. A design with an off-by-one or a swapped limit marks the wrong frame or leaves out the second bit. It sends a bad residue with a good CRC, where a design that ignores the CRC term flags a spurious alignment error. It sends a 13-byte frame holding only the first control-type byte, where a matcher that compares byte 12 alone marks it as a control frame. Halts come both from dropping `rx_enable` and from `halt_now`, alongside a bad CRC flag and an earlier overflow. A design that counts the halting byte, judges the CRC or loses the recorded overflow gives a wrong length or word. A start offered while reception is disabled must leave no trace.

// File: rtl/rx_stat_pkg.sv
// Package rx_stat_pkg
// Holds the status-word bit positions shared by the classifier and its bench-facing documentation.
// Assumes a 16-bit status word whose bit layout is decoded by the descriptor writer downstream.
package rx_stat_pkg;
    localparam int ST_W      = 16;
    localparam int B_OVMAX   = 3;
    localparam int B_CTRL    = 5;
    localparam int B_INT     = 6;
    localparam int B_SLOW    = 7;
    localparam int B_ALIGN   = 8;
    localparam int B_CRC     = 9;
    localparam int B_OVF     = 10;
    localparam int B_LONG    = 11;
    localparam int B_GOOD    = 14;
    localparam int B_HALT    = 15;

    // Mask of every bit that counts as an error for the good flag and the interrupt
    localparam logic [ST_W-1:0] ERR_MASK =
        (ST_W'(1) << B_OVMAX) | (ST_W'(1) << B_ALIGN) | (ST_W'(1) << B_CRC) |
        (ST_W'(1) << B_OVF)   | (ST_W'(1) << B_LONG)  | (ST_W'(1) << B_HALT);

    // Accumulated per-frame event flags
    typedef struct packed {
        logic ovf;
        logic phy;
    } evt_t;
endpackage

// File: rtl/rx_len_track.sv
// Module rx_len_track
// Counts the accepted bytes of the current frame and presents the index of the byte
// on the wire plus the length including that byte. The count saturates at all ones.
// Assumes start is only asserted together with step.
module rx_len_track #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    output logic [LEN_W-1:0] idx,
    output logic [LEN_W-1:0] len_now
);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    logic [LEN_W-1:0] cnt_q;

    // Index of the current byte and the length counting it
    always_comb begin
        idx     = start ? '0 : cnt_q;
        len_now = (step && idx != LEN_MAX) ? idx + 1'b1 : idx;
    end

    // Register the running count
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start || step) cnt_q <= len_now;
    end

    // R1: within a frame the count never goes backwards
    a_r1_count_mono: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/rx_type_match.sv
// Module rx_type_match
// Detects the MAC control type value in the two type bytes of the frame.
// Assumes idx is the zero-based position of the byte presented with step.
module rx_type_match #(
    parameter int          LEN_W    = 16,
    parameter int          TYPE_POS = 12,
    parameter logic [15:0] CTL_TYPE = 16'h8808
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic [LEN_W-1:0] idx,
    input  logic [7:0]       data,
    output logic             is_ctl
);
    localparam logic [LEN_W-1:0] POS_HI = LEN_W'(TYPE_POS);
    localparam logic [LEN_W-1:0] POS_LO = LEN_W'(TYPE_POS + 1);

    logic hi_q, ctl_q, hi_hit, lo_hit;

    // Compare the current byte against the expected half of the type field
    always_comb begin
        hi_hit = step && idx == POS_HI && data == CTL_TYPE[15:8];
        lo_hit = step && !start && idx == POS_LO && data == CTL_TYPE[7:0] && hi_q;
        is_ctl = (!start && ctl_q) || lo_hit;
    end

    // Remember partial and full matches for the rest of the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= 1'b0;
            ctl_q <= 1'b0;
        end else if (step) begin
            hi_q  <= (!start && hi_q) || hi_hit;
            ctl_q <= is_ctl;
        end
    end

    // R7: a full match never stands without the high byte having matched
    a_r7_ctl_needs_hi: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q |-> hi_q);
endmodule

// File: rtl/rx_evt_sticky.sv
// Module rx_evt_sticky
// Holds per-frame event flags from the first cycle they occur until the next frame starts.
// The "now" output already includes events of the current cycle.
module rx_evt_sticky #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] ev,
    output logic [W-1:0] now
);
    logic [W-1:0] q;

    // Merge held flags with this cycle's events
    always_comb now = (clr ? '0 : q) | ev;

    // Hold the merged flags while the frame is active
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= now;
    end

    // R5: a recorded event is not lost until the next frame clears it
    a_r5_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (q & $past(q)) == $past(q));
endmodule

// File: rtl/rx_stat_classifier.sv
// Module rx_stat_classifier
// Classifies one received frame at a time and reports its status word, length and
// interrupt one cycle after the frame ends or is halted.
// Assumes rx_sof and rx_eof are only meaningful with rx_valid, and rx_crc_ok and
// rx_resid are valid on the last byte.
module rx_stat_classifier #(
    parameter int          LEN_W     = 16,
    parameter int          MAX_STORE = 1520,
    parameter int          MAX_LEGAL = 1518,
    parameter int          TYPE_POS  = 12,
    parameter logic [15:0] CTL_TYPE  = 16'h8808
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_sof,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_eof,
    input  logic [2:0]       rx_resid,
    input  logic             rx_phy_err,
    input  logic             rx_fifo_full,
    input  logic             rx_crc_ok,
    input  logic             rx_enable,
    input  logic             halt_now,
    input  logic             long_en,
    input  logic             good_int_en,
    input  logic             path_10m,
    output logic [15:0]      stat_word,
    output logic [LEN_W-1:0] frame_len,
    output logic             stat_done,
    output logic             irq
);
    import rx_stat_pkg::*;

    localparam logic [LEN_W-1:0] LIM_STORE = LEN_W'(MAX_STORE);
    localparam logic [LEN_W-1:0] LIM_LEGAL = LEN_W'(MAX_LEGAL);

    logic             in_frame;
    logic             start, abort, step, active, fin_ok, finish;
    logic [LEN_W-1:0] idx, len_now;
    logic             is_ctl;
    evt_t             ev, evt_now;
    logic [ST_W-1:0]  st_c;
    logic             err_c;

    // Frame control events for this cycle
    always_comb begin
        start  = !in_frame && rx_sof && rx_valid && rx_enable && !halt_now;
        abort  = in_frame && (!rx_enable || halt_now);
        step   = start || (in_frame && !abort && rx_valid);
        active = start || (in_frame && !abort);
        fin_ok = step && rx_eof;
        finish = abort || fin_ok;
        ev.phy = active && rx_phy_err;
        ev.ovf = step && rx_fifo_full;
    end

    rx_len_track #(.LEN_W(LEN_W)) u_len (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .idx(idx), .len_now(len_now)
    );

    rx_type_match #(.LEN_W(LEN_W), .TYPE_POS(TYPE_POS), .CTL_TYPE(CTL_TYPE)) u_type (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .idx(idx), .data(rx_data), .is_ctl(is_ctl)
    );

    rx_evt_sticky #(.W($bits(evt_t))) u_evt (
        .clk(clk), .rst_n(rst_n), .clr(start), .en(active),
        .ev(ev), .now(evt_now)
    );

    // Assemble the status word as it would be reported if the frame ended now
    always_comb begin
        st_c            = '0;
        st_c[B_OVMAX]   = len_now > LIM_STORE;
        st_c[B_LONG]    = (len_now > LIM_LEGAL) && !long_en;
        st_c[B_ALIGN]   = !abort && (rx_resid != 3'd0) && !rx_crc_ok;
        st_c[B_CRC]     = evt_now.phy || (!abort && !rx_crc_ok);
        st_c[B_OVF]     = evt_now.ovf;
        st_c[B_HALT]    = abort;
        st_c[B_CTRL]    = is_ctl;
        st_c[B_SLOW]    = path_10m;
        err_c           = |(st_c & ERR_MASK);
        st_c[B_GOOD]    = !err_c;
        st_c[B_INT]     = err_c || good_int_en;
    end

    // Track frame occupancy and register the report at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame  <= 1'b0;
            stat_word <= '0;
            frame_len <= '0;
            stat_done <= 1'b0;
            irq       <= 1'b0;
        end else begin
            in_frame  <= start ? !fin_ok : (in_frame && !finish);
            stat_done <= finish;
            irq       <= finish && st_c[B_INT];
            if (finish) begin
                stat_word <= st_c;
                frame_len <= len_now;
            end
        end
    end

    // R11: the interrupt pulse coincides with the strobe and the interrupt bit
    a_r11_irq_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done |-> irq == stat_word[B_INT]);
    a_r11_irq_only_done: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_done |-> !irq);
    // R9: a frame marked good carries no error bit
    a_r9_good_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_done && stat_word[B_GOOD]) |-> (stat_word & ERR_MASK) == '0);
    // R3: beyond the stored maximum the long flag must also appear unless allowed
    a_r3_over_means_long: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_done && stat_word[B_OVMAX] && !$past(long_en)) |-> stat_word[B_LONG]);
    // R4: an alignment error always comes with a CRC error
    a_r4_align_has_crc: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_done && stat_word[B_ALIGN]) |-> stat_word[B_CRC]);
    // R1: every reported frame holds at least one byte
    a_r1_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done |-> frame_len != '0);
endmodule

// File: tb/rx_stat_classifier_tb_top.sv
`timescale 1ns/1ps
module rx_stat_classifier_tb_top;
    localparam logic [15:0] NONE = 16'hFFFF;

    typedef struct packed {
        logic [15:0] len;
        logic [2:0]  resid;
        logic        crc_ok;
        logic        ctl;
        logic        lng_en;
        logic        gie;
        logic        p10;
        logic [15:0] phy_at;
        logic [15:0] ovf_at;
        logic [15:0] halt_at;
        logic        halt_kind;
        logic [15:0] exp_st;
        logic [15:0] exp_len;
    } vec_t;

    localparam int NV = 17;
    // len resid crc ctl lng gie p10 phy_at ovf_at halt_at kind exp_st exp_len
    localparam vec_t VECS [NV] = '{
        '{16'd64,   3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, NONE, NONE, NONE, 1'b0, 16'h4000, 16'd64},   // R9 good
        '{16'd64,   3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, NONE, NONE, NONE, 1'b0, 16'h4040, 16'd64},   // R11 good irq
        '{16'd64,   3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, NONE, NONE, NONE, 1'b0, 16'h0240, 16'd64},   // R5 crc
        '{16'd64,   3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, NONE, NONE, NONE, 1'b0, 16'h0340, 16'd64},   // R4 align
        '{16'd64,   3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, NONE, NONE, NONE, 1'b0, 16'h4000, 16'd64},   // R4 resid ok crc
        '{16'd60,   3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, NONE, NONE, NONE, 1'b0, 16'h40A0, 16'd60},   // R7 R8
        '{16'd1518, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, NONE, NONE, NONE, 1'b0, 16'h4000, 16'd1518}, // R3 limit
        '{16'd1519, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, NONE, NONE, NONE, 1'b0, 16'h0840, 16'd1519}, // R3 long
        '{16'd1519, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, NONE, NONE, NONE, 1'b0, 16'h4000, 16'd1519}, // R3 allowed
        '{16'd1520, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, NONE, NONE, NONE, 1'b0, 16'h4000, 16'd1520}, // R2 limit
        '{16'd1521, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, NONE, NONE, NONE, 1'b0, 16'h0048, 16'd1521}, // R2 over
        '{16'd1521, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, NONE, NONE, NONE, 1'b0, 16'h0848, 16'd1521}, // R2 R3 both
        '{16'd64,   3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd10, NONE, NONE, 1'b0, 16'h0240, 16'd64}, // R5 phy
        '{16'd64,   3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, NONE, 16'd30, NONE, 1'b0, 16'h0440, 16'd64}, // R6 ovf
        '{16'd64,   3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, NONE, NONE, 16'd20, 1'b0, 16'h8040, 16'd20}, // R10 enable drop
        '{16'd64,   3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, NONE, 16'd2, 16'd5, 1'b1, 16'h8440, 16'd5},  // R10 halt_now
        '{16'd13,   3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, NONE, NONE, NONE, 1'b0, 16'h4000, 16'd13}    // R7 short
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [2:0]  rx_resid = '0;
    logic        rx_phy_err = 1'b0, rx_fifo_full = 1'b0, rx_crc_ok = 1'b0;
    logic        rx_enable = 1'b1, halt_now = 1'b0;
    logic        long_en = 1'b0, good_int_en = 1'b0, path_10m = 1'b0;
    logic [15:0] stat_word, frame_len;
    logic        stat_done, irq;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    rx_stat_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eof(rx_eof), .rx_resid(rx_resid), .rx_phy_err(rx_phy_err),
        .rx_fifo_full(rx_fifo_full), .rx_crc_ok(rx_crc_ok), .rx_enable(rx_enable),
        .halt_now(halt_now), .long_en(long_en), .good_int_en(good_int_en),
        .path_10m(path_10m), .stat_word(stat_word), .frame_len(frame_len),
        .stat_done(stat_done), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        rx_sof = 1'b0; rx_valid = 1'b0; rx_eof = 1'b0; rx_resid = '0;
        rx_phy_err = 1'b0; rx_fifo_full = 1'b0; rx_crc_ok = 1'b0;
        rx_enable = 1'b1; halt_now = 1'b0;
    endtask

    function automatic logic [7:0] byte_of(input vec_t v, input int i);
        if (i == 12) return v.ctl ? 8'h88 : 8'h08;
        if (i == 13) return v.ctl ? 8'h08 : 8'h00;
        return i[7:0];
    endfunction

    // Drive one frame from the table, then check the report one cycle after its end
    task automatic run_vec(input int k);
        vec_t v;
        v = VECS[k];
        long_en = v.lng_en; good_int_en = v.gie; path_10m = v.p10;
        for (int i = 0; i < int'(v.len); i++) begin
            @(negedge clk);
            if (i == int'(v.halt_at)) begin
                rx_sof = 1'b0; rx_valid = 1'b0; rx_eof = 1'b0;
                rx_phy_err = 1'b0; rx_fifo_full = 1'b0;
                if (v.halt_kind) halt_now = 1'b1; else rx_enable = 1'b0;
                break;
            end
            rx_sof       = (i == 0);
            rx_valid     = 1'b1;
            rx_data      = byte_of(v, i);
            rx_eof       = (i == int'(v.len) - 1);
            rx_resid     = rx_eof ? v.resid : 3'd0;
            rx_crc_ok    = rx_eof ? v.crc_ok : 1'b0;
            rx_phy_err   = (i == int'(v.phy_at));
            rx_fifo_full = (i == int'(v.ovf_at));
        end
        @(negedge clk);
        idle();
        check($sformatf("R1 done vec%0d", k), {31'd0, stat_done}, 32'd1);
        check($sformatf("R1 len vec%0d", k), {16'd0, frame_len}, {16'd0, v.exp_len});
        check($sformatf("R2-R10 status vec%0d", k), {16'd0, stat_word}, {16'd0, v.exp_st});
        check($sformatf("R11 irq vec%0d", k), {31'd0, irq}, {31'd0, v.exp_st[6]});
        @(negedge clk);
        check($sformatf("R1 one-cycle vec%0d", k), {31'd0, stat_done}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13 done", {31'd0, stat_done}, 32'd0);
        check("R13 irq", {31'd0, irq}, 32'd0);
        check("R13 status", {16'd0, stat_word}, 32'd0);
        check("R13 len", {16'd0, frame_len}, 32'd0);

        for (int k = 0; k < NV; k++) run_vec(k);

        // R12: a frame offered while reception is disabled leaves no report
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rx_enable = 1'b0;
            rx_sof = (i == 0); rx_valid = 1'b1; rx_data = 8'h55; rx_eof = (i == 19);
            rx_crc_ok = 1'b0;
            if (stat_done) check("R12 no done while disabled", 32'd1, 32'd0);
        end
        @(negedge clk);
        idle();
        check("R12 no done after disabled frame", {31'd0, stat_done}, 32'd0);
        check("R12 status kept", {16'd0, stat_word}, {16'd0, VECS[NV-1].exp_st});

        // R12: start ignored while halt_now is high, then a normal frame still works
        @(negedge clk);
        halt_now = 1'b1; rx_sof = 1'b1; rx_valid = 1'b1; rx_eof = 1'b1;
        @(negedge clk);
        idle();
        check("R12 halted start ignored", {31'd0, stat_done}, 32'd0);
        run_vec(0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule